// File: doc/BRIEF.md
# Multiplexed DMA Bus Master Interface

This block sits on the system-bus side of a peripheral. The peripheral answers register accesses as a slave, and it can also take the bus as a DMA master on a multiplexed address/data bus. When a transfer is requested and the block holds the bus, it runs a fixed master cycle with four phases. In the latch phase it puts the top address bits on the wide address/data lines and the middle byte on the narrow address pins, and it pulses a low-going load strobe so that an external latch can capture them. In the address phase the low address byte goes onto the narrow pins. In the data phase 16-bit data moves over the shared lines. In the release phase the drivers turn off.

The block also produces the controls for the external buffers: an address-driver enable, a data-buffer enable and a direction line. It provides a bus clock at half the input rate. If a bus error arrives during a master cycle, the cycle is cut short, the bus is freed and an error interrupt is latched. That interrupt blocks further master cycles until the host clears it with a register write.

Top module: `dma_mux_bus_if`

## Requirements
- R1: `bus_clk_o` is 0 in every cycle while `rst` is high. After reset it changes level on every `clk` cycle, so its rate is half of `clk`.
- R2: In the latch phase `adld_n_o` is 0 for exactly two `clk` cycles (one bus-clock period). During that phase `ad_o` carries address bits 31..16 and `la_o` carries bits 15..8, and `ad_oe_o` and `la_oe_o` are both 1.
- R3: In the address phase, which lasts two `clk` cycles after the latch phase, `la_o` carries address bits 7..0 with `la_oe_o`=1, `ad_oe_o`=0 and `adld_n_o`=1.
- R4: In the data phase of a write, `ad_o` carries the write data with `ad_oe_o`=1. In a read, `ad_oe_o` stays 0 and the value on `ad_i` at the end of the phase appears on `xfer_rdata_o`. `xfer_done_o` is a single-cycle pulse at the end of the data phase.
- R5: `wait_i` is sampled only at the end of each data-phase bus period, and each sample of 1 adds one more bus period. With k extensions, `master_o` is 1 for exactly 6+2k `clk` cycles. A `wait_i` of 1 in the latch or address phase has no effect.
- R6: `aen_n_o` is 0 exactly while `master_o` is 1.
- R7: `daten_n_o` is 0 when `master_o`=1 or when both `cs_n_i` and `ds_n_i` are 0. `datdir_n_o` is 0 when `master_o`=1 or when `cs_n_i`=0.
- R8: When the block is not master, `la_oe_o`=0. `ctrl_oe_o` equals `cs_n_i`=0 in that state, and `ad_oe_o` is 1 only during a host register read.
- R9: If `berr_n_i` is 0 in a cycle while `master_o` is 1, then in the next cycle `master_o`=0, `aen_n_o`=1, `la_oe_o`=0 and `err_irq_o`=1, and no `xfer_done_o` pulse follows. A `berr_n_i` of 0 while the block is not master has no effect.
- R10: While `err_irq_o` is 1, `xfer_req_i` starts no master cycle. A host write clears the interrupt. A host write is `cs_n_i`=0, `ds_n_i`=0 and `host_rd_i`=0, with `la_i` equal to `CLR_SEL` (default 8'hF0) and `ad_i[0]`=1. A write to any other `la_i` value leaves the interrupt set.
- R11: During a host register read (`cs_n_i`=0, `ds_n_i`=0, `host_rd_i`=1, not master), `ad_o` equals `reg_rdata_i` and `ad_oe_o`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_clk_o | output | 1 | Bus clock, clk divided by two |
| xfer_req_i | input | 1 | Request for one master transfer |
| xfer_wr_i | input | 1 | 1 = write to memory, 0 = read |
| xfer_addr_i | input | 32 | Transfer address |
| xfer_wdata_i | input | 16 | Write data |
| xfer_done_o | output | 1 | One-cycle pulse when a transfer completes |
| xfer_rdata_o | output | 16 | Data captured by the last read |
| wait_i | input | 1 | Extends the data phase |
| berr_n_i | input | 1 | Bus error, active low |
| cs_n_i | input | 1 | Chip select, active low |
| ds_n_i | input | 1 | Data strobe, active low |
| host_rd_i | input | 1 | Host access direction, 1 = read |
| reg_rdata_i | input | 16 | Register data for host reads |
| la_i | input | 8 | Narrow address pins, input side |
| la_o | output | 8 | Narrow address pins, output side |
| la_oe_o | output | 1 | Drive enable for the narrow address pins |
| ad_i | input | 16 | Address/data lines, input side |
| ad_o | output | 16 | Address/data lines, output side |
| ad_oe_o | output | 1 | Drive enable for the address/data lines |
| adld_n_o | output | 1 | Address-load strobe, active low |
| aen_n_o | output | 1 | External address-driver enable, active low |
| daten_n_o | output | 1 | Data-buffer enable, active low |
| datdir_n_o | output | 1 | Data-buffer direction, active low |
| ctrl_oe_o | output | 1 | Drive enable for the four control strobes |
| master_o | output | 1 | Block currently owns the bus |
| err_irq_o | output | 1 | Pending bus-error interrupt |

## Verification
The hardest situation to reach is a bus error that lands in the middle of a master cycle, followed by the checks that the pending interrupt holds off new cycles and that only the correct host write clears it. The bench locates the latch phase by watching for the load strobe at a falling clock edge. It counts edges from that point to place the error inside the address phase. It then holds the request high for many cycles, makes a host write to a wrong select and then to the right one, and finally runs a normal transfer. Wait-state placement is reached the same way: the bench drops `wait_i` at a computed edge count, so each sweep point produces an exact number of extensions.

// File: rtl/dmabus_pkg.sv
package dmabus_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_LATCH = 3'd1,
    ST_ADDR  = 3'd2,
    ST_DATA  = 3'd3,
    ST_REL   = 3'd4
  } mst_state_e;
endpackage

// File: rtl/busclk_div.sv
module busclk_div (
  input  logic clk,
  input  logic rst,
  output logic phase_o,
  output logic bus_clk_o
);
  logic ph_q;
  always_ff @(posedge clk) begin
    if (rst) ph_q <= 1'b0;
    else     ph_q <= ~ph_q;
  end
  // a bus period ends at the edge where ph_q is high
  assign phase_o   = ph_q;
  assign bus_clk_o = ph_q;
endmodule

// File: rtl/master_fsm.sv
module master_fsm
  import dmabus_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv_i,
  input  logic          req_i,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          wait_i,
  input  logic          berr_n_i,
  input  logic          irq_pend_i,
  input  logic [DW-1:0] ad_i,
  output mst_state_e    state_o,
  output logic [AW-1:0] addr_q_o,
  output logic          wr_q_o,
  output logic [DW-1:0] wdata_q_o,
  output logic          done_o,
  output logic [DW-1:0] rdata_o,
  output logic          berr_hit_o
);
  mst_state_e st_q;
  logic       own;

  assign own        = (st_q == ST_LATCH) || (st_q == ST_ADDR) || (st_q == ST_DATA);
  assign berr_hit_o = own && !berr_n_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_IDLE;
      done_o    <= 1'b0;
      rdata_o   <= '0;
      addr_q_o  <= '0;
      wr_q_o    <= 1'b0;
      wdata_q_o <= '0;
    end else begin
      done_o <= 1'b0;
      if (berr_hit_o) begin
        st_q <= ST_IDLE;
      end else begin
        unique case (st_q)
          ST_IDLE: if (adv_i && req_i && !irq_pend_i) begin
            st_q      <= ST_LATCH;
            addr_q_o  <= addr_i;
            wr_q_o    <= wr_i;
            wdata_q_o <= wdata_i;
          end
          ST_LATCH: if (adv_i) st_q <= ST_ADDR;
          ST_ADDR:  if (adv_i) st_q <= ST_DATA;
          ST_DATA:  if (adv_i && !wait_i) begin
            st_q   <= ST_REL;
            done_o <= 1'b1;
            if (!wr_q_o) rdata_o <= ad_i;
          end
          ST_REL:   if (adv_i) st_q <= ST_IDLE;
          default:  st_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign state_o = st_q;
endmodule

// File: rtl/irq_latch.sv
module irq_latch (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic pend_o
);
  always_ff @(posedge clk) begin
    if (rst)        pend_o <= 1'b0;
    else if (set_i) pend_o <= 1'b1;
    else if (clr_i) pend_o <= 1'b0;
  end
endmodule

// File: rtl/pin_mux.sv
module pin_mux
  import dmabus_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 16,
  parameter int LW = 8
) (
  input  mst_state_e    state_i,
  input  logic [AW-1:0] addr_q_i,
  input  logic          wr_q_i,
  input  logic [DW-1:0] wdata_q_i,
  input  logic          cs_n_i,
  input  logic          ds_n_i,
  input  logic          host_rd_i,
  input  logic [DW-1:0] reg_rdata_i,
  output logic          master_o,
  output logic [LW-1:0] la_o,
  output logic          la_oe_o,
  output logic [DW-1:0] ad_o,
  output logic          ad_oe_o,
  output logic          adld_n_o,
  output logic          aen_n_o,
  output logic          daten_n_o,
  output logic          datdir_n_o,
  output logic          ctrl_oe_o
);
  // address split: top DW bits on ad, next LW bits on la while latching
  localparam int HI_LSB  = AW - DW;
  localparam int MID_LSB = AW - DW - LW;

  logic in_latch, in_data, host_rd;

  always_comb begin
    master_o = (state_i == ST_LATCH) || (state_i == ST_ADDR) || (state_i == ST_DATA);
    in_latch = (state_i == ST_LATCH);
    in_data  = (state_i == ST_DATA);
    host_rd  = !master_o && !cs_n_i && !ds_n_i && host_rd_i;

    la_oe_o  = master_o;
    la_o     = in_latch ? addr_q_i[MID_LSB +: LW] : addr_q_i[LW-1:0];

    ad_oe_o  = in_latch || (in_data && wr_q_i) || host_rd;
    if (in_latch)      ad_o = addr_q_i[HI_LSB +: DW];
    else if (master_o) ad_o = wdata_q_i;
    else               ad_o = reg_rdata_i;

    adld_n_o   = !in_latch;
    aen_n_o    = !master_o;
    daten_n_o  = !(master_o || (!cs_n_i && !ds_n_i));
    datdir_n_o = !(master_o || !cs_n_i);
    ctrl_oe_o  = master_o || !cs_n_i;
  end
endmodule

// File: rtl/dma_mux_bus_if.sv
module dma_mux_bus_if
  import dmabus_pkg::*;
#(
  parameter int          AW      = 32,
  parameter int          DW      = 16,
  parameter int          LW      = 8,
  parameter logic [7:0]  CLR_SEL = 8'hF0
) (
  input  logic          clk,
  input  logic          rst,
  output logic          bus_clk_o,
  input  logic          xfer_req_i,
  input  logic          xfer_wr_i,
  input  logic [AW-1:0] xfer_addr_i,
  input  logic [DW-1:0] xfer_wdata_i,
  output logic          xfer_done_o,
  output logic [DW-1:0] xfer_rdata_o,
  input  logic          wait_i,
  input  logic          berr_n_i,
  input  logic          cs_n_i,
  input  logic          ds_n_i,
  input  logic          host_rd_i,
  input  logic [DW-1:0] reg_rdata_i,
  input  logic [LW-1:0] la_i,
  output logic [LW-1:0] la_o,
  output logic          la_oe_o,
  input  logic [DW-1:0] ad_i,
  output logic [DW-1:0] ad_o,
  output logic          ad_oe_o,
  output logic          adld_n_o,
  output logic          aen_n_o,
  output logic          daten_n_o,
  output logic          datdir_n_o,
  output logic          ctrl_oe_o,
  output logic          master_o,
  output logic          err_irq_o
);
  mst_state_e    state;
  logic          phase, berr_hit, clr_wr, wr_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;

  busclk_div u_div (
    .clk(clk), .rst(rst), .phase_o(phase), .bus_clk_o(bus_clk_o)
  );

  master_fsm #(.AW(AW), .DW(DW)) u_fsm (
    .clk(clk), .rst(rst), .adv_i(phase), .req_i(xfer_req_i),
    .wr_i(xfer_wr_i), .addr_i(xfer_addr_i), .wdata_i(xfer_wdata_i),
    .wait_i(wait_i), .berr_n_i(berr_n_i), .irq_pend_i(err_irq_o),
    .ad_i(ad_i), .state_o(state), .addr_q_o(addr_q), .wr_q_o(wr_q),
    .wdata_q_o(wdata_q), .done_o(xfer_done_o), .rdata_o(xfer_rdata_o),
    .berr_hit_o(berr_hit)
  );

  assign clr_wr = !master_o && !cs_n_i && !ds_n_i && !host_rd_i &&
                  (la_i == CLR_SEL[LW-1:0]) && ad_i[0];

  irq_latch u_irq (
    .clk(clk), .rst(rst), .set_i(berr_hit), .clr_i(clr_wr), .pend_o(err_irq_o)
  );

  pin_mux #(.AW(AW), .DW(DW), .LW(LW)) u_mux (
    .state_i(state), .addr_q_i(addr_q), .wr_q_i(wr_q), .wdata_q_i(wdata_q),
    .cs_n_i(cs_n_i), .ds_n_i(ds_n_i), .host_rd_i(host_rd_i),
    .reg_rdata_i(reg_rdata_i), .master_o(master_o), .la_o(la_o),
    .la_oe_o(la_oe_o), .ad_o(ad_o), .ad_oe_o(ad_oe_o), .adld_n_o(adld_n_o),
    .aen_n_o(aen_n_o), .daten_n_o(daten_n_o), .datdir_n_o(datdir_n_o),
    .ctrl_oe_o(ctrl_oe_o)
  );
endmodule

// File: rtl/dma_mux_bus_if_chk.sv
module dma_mux_bus_if_chk (
  input logic clk,
  input logic rst,
  input logic bus_clk_o,
  input logic xfer_req_i,
  input logic xfer_done_o,
  input logic berr_n_i,
  input logic cs_n_i,
  input logic la_oe_o,
  input logic ad_oe_o,
  input logic adld_n_o,
  input logic aen_n_o,
  input logic ctrl_oe_o,
  input logic master_o,
  input logic err_irq_o
);
  AST_BUSCLK_HIGH_FALLS: assert property (@(posedge clk) disable iff (rst)
    bus_clk_o |=> !bus_clk_o); // R1
  AST_BUSCLK_LOW_RISES: assert property (@(posedge clk) disable iff (rst)
    !bus_clk_o |=> bus_clk_o); // R1
  AST_LATCH_DRIVES: assert property (@(posedge clk) disable iff (rst)
    !adld_n_o |-> (master_o && ad_oe_o && la_oe_o)); // R2
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    xfer_done_o |=> !xfer_done_o); // R4
  AST_AEN_WITH_LA: assert property (@(posedge clk) disable iff (rst)
    la_oe_o |-> !aen_n_o); // R6
  AST_IDLE_TRISTATE: assert property (@(posedge clk) disable iff (rst)
    (!master_o && cs_n_i) |-> (!ad_oe_o && !la_oe_o && !ctrl_oe_o)); // R8
  AST_BERR_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (master_o && !berr_n_i) |=> (!master_o && err_irq_o)); // R9
  AST_IRQ_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    (err_irq_o && !master_o && xfer_req_i) |=> !master_o); // R10
endmodule

bind dma_mux_bus_if dma_mux_bus_if_chk u_chk (.*);

// File: tb/tb_dma_mux_bus_if.sv
module tb_dma_mux_bus_if;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        bus_clk_o;
  logic        xfer_req_i, xfer_wr_i;
  logic [31:0] xfer_addr_i;
  logic [15:0] xfer_wdata_i;
  logic        xfer_done_o;
  logic [15:0] xfer_rdata_o;
  logic        wait_i, berr_n_i, cs_n_i, ds_n_i, host_rd_i;
  logic [15:0] reg_rdata_i;
  logic [7:0]  la_i, la_o;
  logic        la_oe_o;
  logic [15:0] ad_i, ad_o;
  logic        ad_oe_o, adld_n_o, aen_n_o, daten_n_o, datdir_n_o, ctrl_oe_o;
  logic        master_o, err_irq_o;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit ended  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_mux_bus_if dut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=<20000", cyc);
      finish_run();
    end
  end

  task automatic wait_latch();
    int guard = 0;
    do begin
      @(negedge clk);
      guard++;
    end while (adld_n_o && guard < 50);
    check("R2 latch seen", {31'd0, adld_n_o}, 32'd0);
  endtask

  task automatic run_xfer(input logic [31:0] a, input logic wr, input logic [15:0] wd,
                          input int k, input logic [15:0] drv);
    int mcnt = 0;
    int dcnt = 0;
    xfer_addr_i  = a;
    xfer_wr_i    = wr;
    xfer_wdata_i = wd;
    ad_i         = drv;
    wait_i       = (k > 0);
    xfer_req_i   = 1'b1;
    wait_latch();
    xfer_req_i = 1'b0;
    for (int n = 0; n <= 10 + 2*k; n++) begin
      if (n > 0) @(negedge clk);
      if (master_o) mcnt++;
      if (xfer_done_o) dcnt++;
      check("R6 aen", {31'd0, aen_n_o}, {31'd0, !master_o});
      if (n == 0) begin
        check("R2 ad hi", {16'd0, ad_o}, {16'd0, a[31:16]});
        check("R2 la mid", {24'd0, la_o}, {24'd0, a[15:8]});
        check("R2 oe", {30'd0, ad_oe_o, la_oe_o}, 32'd3);
      end
      if (n == 1) check("R2 latch len", {31'd0, adld_n_o}, 32'd0);
      if (n == 2 || n == 3) begin
        check("R3 strobe", {31'd0, adld_n_o}, 32'd1);
        check("R3 la low", {24'd0, la_o}, {24'd0, a[7:0]});
        check("R3 oe", {30'd0, ad_oe_o, la_oe_o}, 32'd1);
        check("R7 master buf", {30'd0, daten_n_o, datdir_n_o}, 32'd0);
      end
      if (n == 4) begin
        check("R4 data oe", {31'd0, ad_oe_o}, {31'd0, wr});
        if (wr) check("R4 wdata", {16'd0, ad_o}, {16'd0, wd});
      end
      if (k > 0 && n == 4 + 2*k) wait_i = 1'b0;
    end
    check("R5 master len", mcnt, 6 + 2*k);
    check("R4 done pulses", dcnt, 1);
    if (!wr) check("R4 rdata", {16'd0, xfer_rdata_o}, {16'd0, drv});
  endtask

  initial begin
    rst = 1'b1;
    xfer_req_i = 0; xfer_wr_i = 0; xfer_addr_i = '0; xfer_wdata_i = '0;
    wait_i = 0; berr_n_i = 1; cs_n_i = 1; ds_n_i = 1; host_rd_i = 0;
    reg_rdata_i = 16'hA5C3; la_i = 8'h00; ad_i = '0;
    repeat (4) @(negedge clk);
    check("R1 reset busclk", {31'd0, bus_clk_o}, 32'd0);
    check("R6 reset state", {29'd0, adld_n_o, aen_n_o, master_o}, 32'd6);
    check("R10 reset irq", {31'd0, err_irq_o}, 32'd0);
    rst = 1'b0;
    begin
      logic prev;
      @(negedge clk);
      prev = bus_clk_o;
      for (int i = 0; i < 8; i++) begin
        @(negedge clk);
        check("R1 toggle", {31'd0, bus_clk_o}, {31'd0, !prev});
        prev = bus_clk_o;
      end
    end

    // host-side sweep while idle: R7, R8, R11
    for (int v = 0; v < 8; v++) begin
      cs_n_i = v[0]; ds_n_i = v[1]; host_rd_i = v[2];
      #1;
      check("R7 daten", {31'd0, daten_n_o}, {31'd0, !(!v[0] && !v[1])});
      check("R7 datdir", {31'd0, datdir_n_o}, {31'd0, v[0]});
      check("R8 ctrl oe", {31'd0, ctrl_oe_o}, {31'd0, !v[0]});
      check("R8 la oe", {31'd0, la_oe_o}, 32'd0);
      check("R11 ad oe", {31'd0, ad_oe_o}, {31'd0, !v[0] && !v[1] && v[2]});
      if (!v[0] && !v[1] && v[2]) check("R11 rdata", {16'd0, ad_o}, 32'h0000A5C3);
      @(negedge clk);
    end
    cs_n_i = 1; ds_n_i = 1; host_rd_i = 0;

    // transfer sweep: direction x wait extensions (R2..R6)
    for (int wr = 0; wr < 2; wr++)
      for (int k = 0; k < 4; k++) begin
        logic [31:0] a;
        a = 32'h1234_5678 ^ (32'h0101_0101 * k) ^ {31'd0, wr[0]} ^ (32'h8000_0000 * wr);
        run_xfer(a, wr[0], 16'hBEE0 + 16'(k), k, 16'h3C00 + 16'(k * 3));
        repeat (2) @(negedge clk);
      end

    // bus error when idle is ignored (R9)
    berr_n_i = 0;
    repeat (4) @(negedge clk);
    berr_n_i = 1;
    check("R9 idle berr", {31'd0, err_irq_o}, 32'd0);

    // bus error in address phase (R9)
    begin
      int dcnt = 0;
      xfer_addr_i = 32'hCAFE_F00D; xfer_wr_i = 1; xfer_req_i = 1;
      wait_latch();
      xfer_req_i = 0;
      repeat (2) @(negedge clk);
      berr_n_i = 0;
      @(negedge clk);
      berr_n_i = 1;
      check("R9 release", {28'd0, master_o, aen_n_o, la_oe_o, err_irq_o}, 32'b0101);
      for (int i = 0; i < 10; i++) begin
        @(negedge clk);
        if (xfer_done_o) dcnt++;
      end
      check("R9 no done", dcnt, 0);
    end

    // pending irq blocks cycles (R10)
    begin
      int mcnt = 0;
      xfer_wr_i = 0; xfer_req_i = 1;
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        if (master_o) mcnt++;
      end
      check("R10 blocked", mcnt, 0);
      xfer_req_i = 0;
    end
    // wrong select keeps irq
    cs_n_i = 0; ds_n_i = 0; host_rd_i = 0; la_i = 8'hF1; ad_i = 16'h0001;
    @(negedge clk);
    cs_n_i = 1; ds_n_i = 1;
    @(negedge clk);
    check("R10 wrong sel", {31'd0, err_irq_o}, 32'd1);
    // correct select clears
    cs_n_i = 0; ds_n_i = 0; la_i = 8'hF0; ad_i = 16'h0001;
    @(negedge clk);
    cs_n_i = 1; ds_n_i = 1; la_i = 8'h00;
    @(negedge clk);
    check("R10 cleared", {31'd0, err_irq_o}, 32'd0);
    run_xfer(32'h0F0E_0D0C, 1'b0, 16'h0, 1, 16'h7E81);

    finish_run();
  end
endmodule